// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is a synthesizable SPI slave that acts like a 1024-byte serial EEPROM. A bus master selects it with an active-low chip select, clocks it in SPI mode 0 (data captured on the rising SCK edge and changed on the falling edge, most significant bit first), and sends an 8-bit instruction. That instruction may be followed by an address and data. The SPI pins are oversampled by the block's own system clock, so every SCK phase must last several system clocks.

The block holds a small status register. It has a busy bit, a write-enable latch, two block-protect bits that fence off the upper part of the array, and a lock bit that freezes the status register. Data and status writes are collected while the device is selected. They take effect only when chip select is released cleanly, and each one starts a timed busy interval. During that interval the only instruction served is the status read.

Top module: `spi_eeprom_slave`

## Requirements
- R1: The status byte reads as bit 7 = status lock, bits 3:2 = block protect, bit 1 = write-enable latch, bit 0 = busy, with bits 6:4 always 0. Instruction 0x05 returns this byte, and it repeats the current value for every further byte clocked while selected. After reset it reads 0x00.
- R2: Instruction 0x06 sets the write-enable latch and instruction 0x04 clears it.
- R3: Instruction 0x03 is followed by two address bytes, high byte first. Only the low 10 address bits are used. Data bytes then stream out MSB first from consecutive addresses, and the address wraps from 0x3FF to 0x000.
- R4: Instruction 0x02 is followed by two address bytes and then one or more data bytes. The data bytes are stored to consecutive addresses, wrapping at 0x3FF, up to BUF_BYTES bytes. The array changes only during the busy interval that the write starts.
- R5: A data or status write is committed only if three things hold when chip select rises: the latch is set, at least one data byte was received, and the rise falls on a byte boundary. Otherwise the write has no effect at all: the array, the latch and the busy bit are left unchanged.
- R6: A committed write sets busy for exactly WR_CYCLES clocks. Once busy ends, the write-enable latch reads 0.
- R7: While busy is 1, every instruction other than 0x05 is ignored. This covers data writes, status writes, reads and latch changes.
- R8: Instruction 0x01 followed by a data byte loads bit 7 and bits 3:2 of that byte into the status register. The other bits of the byte are ignored. The commit rules of R5 apply, and the write starts a busy interval.
- R9: Block protect 01 guards 0x300 to 0x3FF, 10 guards 0x200 to 0x3FF, 11 guards the whole array, and 00 guards nothing. Bytes aimed at a guarded address are dropped, while unguarded bytes in the same write are stored.
- R10: Once the status lock bit is 1, a status write changes nothing and starts no busy interval.
- R11: miso_o is 0 whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the SPI pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | SPI serial clock, mode 0 |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master, 0 when deselected |

## Verification
The SPI pins pass through two synchroniser stages and one edge register. As a result, a response bit appears on miso_o three system clocks after the falling SCK edge that shifts it out. The bench samples miso_o six clocks after that edge, just before the next rising edge. A commit happens three clocks after chip select rises, and the bench keeps chip select high for ten clocks before it issues a status read, which then sees the busy bit set. The busy interval lasts WR_CYCLES clocks, so the bench waits WR_CYCLES plus 20 clocks before it treats the model as idle. The exact length of the interval is also checked clock by clock against a counter.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [7:0] {
    OP_WRSR  = 8'h01,
    OP_WRITE = 8'h02,
    OP_READ  = 8'h03,
    OP_WRDI  = 8'h04,
    OP_RDSR  = 8'h05,
    OP_WREN  = 8'h06
  } op_e;

  typedef enum logic [2:0] {
    ST_OPC, ST_AHI, ST_ALO, ST_RDD, ST_WRD, ST_RDS, ST_WRS, ST_SKIP
  } cmd_st_e;

  // top2 = two most significant address bits
  function automatic logic is_locked(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/spi_eep_sync.sv
module spi_eep_sync #(
  parameter int             W      = 3,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_eep_link.sv
module spi_eep_link
  import spi_eep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              sck_s_i,
  input  logic              mosi_s_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              sel_o,
  output logic              cs_rise_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              boundary_o,
  output logic              tx_load_o,
  output logic              miso_bit_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sck_q, cs_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic              sck_rise, sck_fall;

  assign sck_rise    = sck_s_i & ~sck_q;
  assign sck_fall    = ~sck_s_i & sck_q;
  assign sel_o       = ~cs_s_i;
  assign cs_rise_o   = cs_s_i & ~cs_q;
  assign boundary_o  = (bit_cnt == '0);
  assign byte_done_o = sel_o & sck_rise & (bit_cnt == CNT_W'(BYTE_W - 1));
  assign rx_byte_o   = {rx_sr, mosi_s_i};
  assign tx_load_o   = sel_o & sck_fall & boundary_o;
  assign miso_bit_o  = tx_sr[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
    end else begin
      sck_q <= sck_s_i;
      cs_q  <= cs_s_i;
      if (!sel_o) begin
        bit_cnt <= '0;
        rx_sr   <= '0;
        tx_sr   <= '0;
      end else begin
        if (sck_rise) begin
          rx_sr   <= {rx_sr[BYTE_W-3:0], mosi_s_i};
          bit_cnt <= bit_cnt + 1'b1;
        end
        // response bytes start on byte boundaries only
        if (sck_fall) tx_sr <= boundary_o ? tx_byte_i : {tx_sr[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_eep_mem.sv
module spi_eep_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/spi_eep_ctrl.sv
module spi_eep_ctrl
  import spi_eep_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BUF_BYTES = 16,
  parameter int WR_CYCLES = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              cs_rise_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              boundary_i,
  input  logic              tx_load_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic [BYTE_W-1:0] status_o
);
  localparam int BUF_IW = $clog2(BUF_BYTES);
  localparam int CNT_W  = $clog2(BUF_BYTES + 1);
  localparam int TMR_W  = $clog2(WR_CYCLES + 1);
  localparam int HI_W   = ADDR_W - BYTE_W;

  cmd_st_e           st;
  logic [ADDR_W-1:0] addr, wbase;
  logic              is_wr;
  logic [BYTE_W-1:0] wbuf [BUF_BYTES];
  logic [CNT_W-1:0]  wcnt, fl_idx;
  logic              fl_on;
  logic [2:0]        sr_pend;   // {lock, bp[1:0]}
  logic              sr_got;
  logic              wel, wip, srwd;
  logic [1:0]        bp;
  logic [TMR_W-1:0]  tmr;
  logic              commit_wr, commit_sr, fl_live;

  assign status_o  = {srwd, 3'b000, bp, wel, wip};
  assign commit_wr = cs_rise_i & boundary_i & (st == ST_WRD) & wel & (wcnt != '0);
  assign commit_sr = cs_rise_i & boundary_i & (st == ST_WRS) & sr_got & wel & ~srwd;
  assign fl_live   = wip & fl_on & (fl_idx < wcnt);

  assign mem_raddr_o = addr;
  assign mem_waddr_o = wbase + ADDR_W'(fl_idx);
  assign mem_wdata_o = wbuf[fl_idx[BUF_IW-1:0]];
  assign mem_we_o    = fl_live & ~is_locked(bp, mem_waddr_o[ADDR_W-1 -: 2]);

  always_comb begin
    case (st)
      ST_RDS:  tx_byte_o = status_o;
      ST_RDD:  tx_byte_o = mem_rdata_i;
      default: tx_byte_o = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (sel_i && byte_done_i && st == ST_WRD && wcnt < CNT_W'(BUF_BYTES))
      wbuf[wcnt[BUF_IW-1:0]] <= rx_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_OPC;
      addr    <= '0;
      wbase   <= '0;
      is_wr   <= 1'b0;
      wcnt    <= '0;
      fl_idx  <= '0;
      fl_on   <= 1'b0;
      sr_pend <= '0;
      sr_got  <= 1'b0;
      wel     <= 1'b0;
      wip     <= 1'b0;
      srwd    <= 1'b0;
      bp      <= '0;
      tmr     <= '0;
    end else begin
      if (!sel_i) begin
        st <= ST_OPC;
      end else if (byte_done_i) begin
        case (st)
          ST_OPC: begin
            if (wip) begin
              st <= (rx_byte_i == OP_RDSR) ? ST_RDS : ST_SKIP;
            end else begin
              case (rx_byte_i)
                OP_WREN:  begin wel <= 1'b1; st <= ST_SKIP; end
                OP_WRDI:  begin wel <= 1'b0; st <= ST_SKIP; end
                OP_RDSR:  st <= ST_RDS;
                OP_WRSR:  begin st <= ST_WRS; sr_got <= 1'b0; end
                OP_READ:  begin st <= ST_AHI; is_wr <= 1'b0; end
                OP_WRITE: begin st <= ST_AHI; is_wr <= 1'b1; wcnt <= '0; end
                default:  st <= ST_SKIP;
              endcase
            end
          end
          ST_AHI: begin
            addr[ADDR_W-1:BYTE_W] <= rx_byte_i[HI_W-1:0];
            st <= ST_ALO;
          end
          ST_ALO: begin
            addr[BYTE_W-1:0] <= rx_byte_i;
            st <= is_wr ? ST_WRD : ST_RDD;
          end
          ST_WRD: if (wcnt < CNT_W'(BUF_BYTES)) wcnt <= wcnt + 1'b1;
          ST_WRS: begin
            sr_pend <= {rx_byte_i[7], rx_byte_i[3:2]};
            sr_got  <= 1'b1;
          end
          default: ;
        endcase
      end

      if (sel_i && tx_load_i && st == ST_RDD) addr <= addr + 1'b1;

      if (commit_sr) begin
        srwd <= sr_pend[2];
        bp   <= sr_pend[1:0];
      end

      if (commit_wr || commit_sr) begin
        wip    <= 1'b1;
        tmr    <= '0;
        fl_idx <= '0;
        fl_on  <= commit_wr;
        wbase  <= addr;
      end else if (wip) begin
        tmr <= tmr + 1'b1;
        if (fl_live) fl_idx <= fl_idx + 1'b1;
        if (tmr == TMR_W'(WR_CYCLES - 1)) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_eep_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BUF_BYTES = 16,
  parameter int WR_CYCLES = 2000,
  parameter int SYNC_LEN  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o
);
  logic [2:0]        pins_s;
  logic              sel, cs_rise, byte_done, boundary, tx_load, miso_bit;
  logic [BYTE_W-1:0] rx_byte, tx_byte, mem_rdata, mem_wdata, status_w;
  logic [ADDR_W-1:0] mem_raddr, mem_waddr;
  logic              mem_we;

  // order: {cs, sck, mosi}; chip select idles high
  spi_eep_sync #(.W(3), .STAGES(SYNC_LEN), .INIT(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i, mosi_i}),
    .q_o    (pins_s)
  );

  spi_eep_link u_link (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_s_i      (pins_s[2]),
    .sck_s_i     (pins_s[1]),
    .mosi_s_i    (pins_s[0]),
    .tx_byte_i   (tx_byte),
    .sel_o       (sel),
    .cs_rise_o   (cs_rise),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte),
    .boundary_o  (boundary),
    .tx_load_o   (tx_load),
    .miso_bit_o  (miso_bit)
  );

  spi_eep_ctrl #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel),
    .cs_rise_i   (cs_rise),
    .byte_done_i (byte_done),
    .rx_byte_i   (rx_byte),
    .boundary_i  (boundary),
    .tx_load_i   (tx_load),
    .mem_rdata_i (mem_rdata),
    .tx_byte_o   (tx_byte),
    .mem_raddr_o (mem_raddr),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .mem_wdata_o (mem_wdata),
    .status_o    (status_w)
  );

  spi_eep_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  // gated by the raw pin so the line drops as soon as the master deselects
  assign miso_o = miso_bit & ~cs_ni;
endmodule

// File: rtl/spi_eeprom_slave_chk.sv
module spi_eeprom_slave_chk
  import spi_eep_pkg::*;
#(
  parameter int WR_CYCLES = 2000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] status_i,
  input logic       mem_we_i,
  input logic [1:0] waddr_top_i
);
  int busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_run <= 0;
    else if (status_i[0]) busy_run <= busy_run + 1;
    else                  busy_run <= 0;
  end

  AST_PROT_HONOURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> !is_locked(status_i[3:2], waddr_top_i)); // R9
  AST_MEM_WR_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> status_i[0]); // R4
  AST_BUSY_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_i[0]) |-> busy_run == WR_CYCLES); // R6
  AST_WEL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_i[0]) |-> !status_i[1]); // R6
  AST_SR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[0] && $past(status_i[0])) |-> $stable(status_i[7:2])); // R7
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[7] |=> status_i[7]); // R10
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .status_i    (status_w),
  .mem_we_i    (mem_we),
  .waddr_top_i (mem_waddr[ADDR_W-1 -: 2])
);

// File: tb/spi_eeprom_slave_test.sv
module spi_eeprom_slave_test;
  localparam int HALF = 6;
  localparam int WRC  = 2000;

  logic clk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int   n_cmp = 0, n_bad = 0;

  logic [7:0] mem_m [int];
  bit         m_wel, m_busy, m_srwd;
  bit   [1:0] m_bp;

  always #10 clk = ~clk;

  spi_eeprom_slave uut (
    .clk_i (clk), .rst_ni (rst_ni), .cs_ni (cs_ni),
    .sck_i (sck), .mosi_i (mosi), .miso_o (miso)
  );

  function automatic logic [7:0] m_status();
    return {m_srwd, 3'b000, m_bp, m_wel, m_busy};
  endfunction

  function automatic bit m_locked(int a);
    case (m_bp)
      2'd1:    return a >= 'h300;
      2'd2:    return a >= 'h200;
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // R11: output quiet whenever deselected, compared each clock
  always @(negedge clk) begin
    if (rst_ni && cs_ni) begin
      n_cmp++;
      if (miso !== 1'b0) begin
        n_bad++;
        $display("FAIL R11: miso %b expected 0 while deselected", miso);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_on();
    cs_ni = 1'b0;
    tick(HALF);
  endtask

  task automatic sel_off();
    tick(HALF);
    cs_ni = 1'b1;
    tick(HALF + 4);
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] d;
    sel_on(); xb(op, d); sel_off();
    if (!m_busy) begin
      if (op == 8'h06) m_wel = 1'b1;
      if (op == 8'h04) m_wel = 1'b0;
    end
  endtask

  task automatic rdsr(string req);
    logic [7:0] d;
    sel_on(); xb(8'h05, d);
    xb(8'h00, d); check8(req, d, m_status());
    xb(8'h00, d); check8(req, d, m_status());
    sel_off();
  endtask

  // n bytes taken from d, most significant byte first
  task automatic wr(input logic [15:0] a, input int n, input logic [31:0] d);
    logic [7:0] r;
    sel_on(); xb(8'h02, r); xb(a[15:8], r); xb(a[7:0], r);
    for (int i = 0; i < n; i++) xb(d[31-8*i -: 8], r);
    sel_off();
    if (!m_busy && m_wel && n > 0) begin
      for (int i = 0; i < n; i++) begin
        int ad = (int'(a) + i) % 1024;
        if (!m_locked(ad)) mem_m[ad] = d[31-8*i -: 8];
      end
      m_busy = 1'b1;
    end
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel_on(); xb(8'h01, r); xb(v, r); sel_off();
    if (!m_busy && m_wel && !m_srwd) begin
      m_bp = v[3:2]; m_srwd = v[7]; m_busy = 1'b1;
    end
  endtask

  task automatic rd(input logic [15:0] a, input int n, string req);
    logic [7:0] r;
    sel_on(); xb(8'h03, r); xb(a[15:8], r); xb(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      xb(8'h00, r);
      check8(req, r, mem_m[(int'(a) + i) % 1024]);
    end
    sel_off();
  endtask

  task automatic settle();
    tick(WRC + 20);
    if (m_busy) begin m_busy = 1'b0; m_wel = 1'b0; end
  endtask

  initial begin
    tick(190000);
    n_bad++;
    $display("FAIL watchdog: run did not end, got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    tick(5); rst_ni = 1'b1; tick(5);
    check8("R11 reset miso", {7'b0, miso}, 8'h00);
    rdsr("R1 reset status");

    op1(8'h06); rdsr("R2 enable latch");
    op1(8'h04); rdsr("R2 disable latch");

    op1(8'h06); wr(16'h0010, 3, 32'h112233_00);
    rdsr("R6 busy after commit");
    settle(); rdsr("R6 idle and latch cleared");
    rd(16'h0010, 3, "R4 burst write");

    wr(16'h0010, 1, 32'h99_000000);
    rdsr("R5 no latch no busy"); rd(16'h0010, 1, "R5 no latch");

    op1(8'h06); wr(16'h03FE, 3, 32'hA1A2A3_00); settle();
    rd(16'h03FE, 3, "R3 wrap read");
    op1(8'h06); wr(16'hFC05, 1, 32'h5C_000000); settle();
    rd(16'hAC05, 1, "R3 high address bits");

    // R7: commands during busy
    op1(8'h06); wr(16'h0020, 1, 32'h44_000000);
    wr(16'h0011, 1, 32'h55_000000);
    wrsr(8'h0C);
    op1(8'h04);
    rdsr("R7 busy ignores commands");
    settle(); rdsr("R7 after busy");
    rd(16'h0010, 3, "R7 write ignored");

    // R5: chip select released mid-byte
    op1(8'h06);
    sel_on(); xb(8'h02, d); xb(8'h00, d); xb(8'h12, d); xb(8'h77, d); xbits(8'hFF, 3, d); sel_off();
    rdsr("R5 partial byte"); rd(16'h0012, 1, "R5 partial byte");
    op1(8'h04);

    op1(8'h06); wr(16'h02FE, 4, 32'hB0B1B2B3); settle();
    op1(8'h06); wr(16'h01FE, 4, 32'hC0C1C2C3); settle();

    for (int b = 1; b < 4; b++) begin
      logic [7:0] bs = 8'(b << 4);
      op1(8'h06); wrsr(8'(b << 2)); settle();
      rdsr("R8 block protect set");
      op1(8'h06); wr(16'h02FE, 4, {bs, bs + 8'd1, bs + 8'd2, bs + 8'd3}); settle();
      op1(8'h06); wr(16'h01FE, 4, {bs + 8'd4, bs + 8'd5, bs + 8'd6, bs + 8'd7}); settle();
      op1(8'h06); wr(16'h0000, 1, {bs + 8'd8, 24'h0}); settle();
      rd(16'h02FE, 4, "R9 upper range");
      rd(16'h01FE, 4, "R9 mid range");
      rd(16'h0000, 1, "R9 low range");
    end

    op1(8'h06); wrsr(8'h8F);
    rdsr("R8 status write");
    settle(); rdsr("R1 reserved bits zero");
    op1(8'h06); wrsr(8'h00);
    rdsr("R10 status locked");

    summary();
    $finish;
  end
endmodule